// File: doc/BRIEF.md
# Split-Counter Toggle and PWM Timer

This block drives two waveform pins, a low pin and a high pin, from one pair of 8-bit counters. A 2-bit mode selects how the pair is used. It can run as two separate 8-bit interval timers that each flip a pin, or as two free-running 8-bit PWM channels. It can also run as one 16-bit interval timer that flips the high pin, in which case the low pin either flips on low-byte matches or carries a PWM waveform taken from the low byte. The counters only advance on cycles where the `tick` enable from an outside prescaler is high.

Software writes the mode, two period bytes and two compare bytes through a small write port. Period and compare writes go into holding registers. They reach the active set only when the counter that uses them wraps, or when the mode register is written, so a running waveform never shows a short glitch pulse. Each half raises a one-cycle event pulse, and the two pulses are ORed onto one shared request line.

Top module: `dual_pwm_timer`

## Requirements
- R1: After reset, `out_lo`, `out_hi`, `irq_lo`, `irq_hi` and `irq` are 0 and the mode is 0.
- R2: Mode 0 (write address 0, data bits [1:0] = 0): each half counts ticks from 0 up to its own period byte, then returns to 0. On the tick where it matches, its pin flips, so the pin flips once every period+1 ticks. The low half uses address 1 and drives `out_lo`; the high half uses address 2 and drives `out_hi`.
- R3: Mode 1: each half counts 0 to 255 and wraps. The pin of each half is 1 while its count is below its compare byte, and 0 otherwise. The low compare is at address 3 and the high compare at address 4. A compare of 0 keeps the pin at 0.
- R4: Mode 2: the halves form a 16-bit counter {high, low} that returns to 0 on the tick where it equals {period high, period low}, and `out_hi` flips on that tick. `out_lo` flips on every tick where the low byte equals the low period byte.
- R5: Mode 3: `out_hi` and the 16-bit count behave as in R4. `out_lo` is 1 while the low byte is below the low compare byte.
- R6: A write to addresses 1 to 4 changes the waveform only at the next wrap of the counter that uses it. In modes 0 and 1 that is the half's own match or wrap. In modes 2 and 3 it is the 16-bit match for the periods, and in mode 3 the low-byte return to 0 for the low compare.
- R7: A write to address 0 clears both counters, both toggle states and both event pulses, and moves all held period and compare values into the active set.
- R8: `irq_lo` and `irq_hi` are 1 for one cycle after a tick on which that half had an event: a match in modes 0 and 2, a wrap in mode 1, the 16-bit match for the high half in modes 2 and 3, and a low-byte return to 0 for the low half in mode 3. `irq` is the OR of the two.
- R9: On cycles without `tick`, the counters, the toggle outputs and the event pulses do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from a prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 mode, 1 period low, 2 period high, 3 compare low, 4 compare high |
| wr_data | input | 8 | Write data |
| out_lo | output | 1 | Low-side toggle/PWM pin |
| out_hi | output | 1 | High-side toggle/PWM pin |
| irq_lo | output | 1 | Low-half event pulse |
| irq_hi | output | 1 | High-half event pulse |
| irq | output | 1 | Shared request, OR of both pulses |

## Verification
A tick or a write at a rising edge updates the counters, the toggle states and the event pulses at that same edge. Toggle pins and event pulses are therefore due one edge after the stimulus. PWM pins follow the count and the active compare with no further delay. The bench drives inputs on the falling edge and moves its behavioural model on the rising edge. It compares all five outputs at the next falling edge, which is exactly where each result has settled. The stimulus includes sparse ticks, compare and period writes in the middle of a period, and mode writes in the middle of a count, so the one-edge latency is checked in every mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned HALF_W = 8;
    localparam int unsigned FULL_W = 2 * HALF_W;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
    localparam logic [ADDR_W-1:0] A_PER_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_PER_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd4;

    typedef enum logic [1:0] {
        MD_TOG8  = 2'd0,
        MD_PWM8  = 2'd1,
        MD_TOG16 = 2'd2,
        MD_MIX16 = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic [HALF_W-1:0] per_lo;
        logic [HALF_W-1:0] per_hi;
        logic [HALF_W-1:0] cmp_lo;
        logic [HALF_W-1:0] cmp_hi;
    } tmr_cfg_t;

    typedef struct packed {
        logic per_lo;
        logic per_hi;
        logic cmp_lo;
        logic cmp_hi;
    } tmr_load_t;

    function automatic logic lo_is_pwm(tmr_mode_e m);
        return (m == MD_PWM8) || (m == MD_MIX16);
    endfunction

    function automatic logic lo_is_tog(tmr_mode_e m);
        return (m == MD_TOG8) || (m == MD_TOG16);
    endfunction

endpackage

// File: rtl/tmr_cfg.sv
module tmr_cfg
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              mode_wr,
    input  tmr_load_t         ld,
    output tmr_mode_e         mode,
    output tmr_cfg_t          act
);
    tmr_cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MD_TOG8;
            shadow <= '0;
            act    <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_MODE:   mode          <= tmr_mode_e'(wr_data[1:0]);
                    A_PER_LO: shadow.per_lo <= wr_data;
                    A_PER_HI: shadow.per_hi <= wr_data;
                    A_CMP_LO: shadow.cmp_lo <= wr_data;
                    A_CMP_HI: shadow.cmp_hi <= wr_data;
                    default: ;
                endcase
            end
            if (mode_wr) begin
                act <= shadow;
            end else begin
                if (ld.per_lo) act.per_lo <= shadow.per_lo;
                if (ld.per_hi) act.per_hi <= shadow.per_hi;
                if (ld.cmp_lo) act.cmp_lo <= shadow.cmp_lo;
                if (ld.cmp_hi) act.cmp_hi <= shadow.cmp_hi;
            end
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              mode_wr,
    input  tmr_mode_e         mode,
    input  tmr_cfg_t          act,
    output logic [HALF_W-1:0] cnt_lo,
    output logic [HALF_W-1:0] cnt_hi,
    output logic              ev_lo,
    output logic              ev_hi,
    output tmr_load_t         ld
);
    logic [HALF_W-1:0] nxt_lo, nxt_hi;
    logic [FULL_W-1:0] inc16;
    logic lo_hit, hi_hit, lo_top, hi_top, full_hit;
    logic raw_lo, raw_hi;

    assign lo_hit   = (cnt_lo == act.per_lo);
    assign hi_hit   = (cnt_hi == act.per_hi);
    assign lo_top   = (cnt_lo == {HALF_W{1'b1}});
    assign hi_top   = (cnt_hi == {HALF_W{1'b1}});
    assign full_hit = lo_hit && hi_hit;
    assign inc16    = {cnt_hi, cnt_lo} + FULL_W'(1);

    always_comb begin
        nxt_lo = cnt_lo;
        nxt_hi = cnt_hi;
        raw_lo = 1'b0;
        raw_hi = 1'b0;
        if (tick) begin
            case (mode)
                MD_TOG8: begin
                    raw_lo = lo_hit;
                    raw_hi = hi_hit;
                    nxt_lo = lo_hit ? '0 : cnt_lo + HALF_W'(1);
                    nxt_hi = hi_hit ? '0 : cnt_hi + HALF_W'(1);
                end
                MD_PWM8: begin
                    raw_lo = lo_top;
                    raw_hi = hi_top;
                    nxt_lo = cnt_lo + HALF_W'(1);
                    nxt_hi = cnt_hi + HALF_W'(1);
                end
                default: begin
                    raw_hi = full_hit;
                    raw_lo = (mode == MD_TOG16) ? lo_hit : (full_hit || lo_top);
                    if (full_hit) begin
                        nxt_lo = '0;
                        nxt_hi = '0;
                    end else begin
                        {nxt_hi, nxt_lo} = inc16;
                    end
                end
            endcase
        end
    end

    assign ev_lo = raw_lo && !mode_wr;
    assign ev_hi = raw_hi && !mode_wr;

    always_comb begin
        ld = '0;
        case (mode)
            MD_TOG8: begin
                ld.per_lo = ev_lo;
                ld.per_hi = ev_hi;
            end
            MD_PWM8: begin
                ld.cmp_lo = ev_lo;
                ld.cmp_hi = ev_hi;
            end
            default: begin
                ld.per_lo = ev_hi;
                ld.per_hi = ev_hi;
                ld.cmp_lo = (mode == MD_MIX16) && ev_lo;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || mode_wr) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else begin
            cnt_lo <= nxt_lo;
            cnt_hi <= nxt_hi;
        end
    end
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  tmr_mode_e         mode,
    input  tmr_cfg_t          act,
    input  logic [HALF_W-1:0] cnt_lo,
    input  logic [HALF_W-1:0] cnt_hi,
    input  logic              ev_lo,
    input  logic              ev_hi,
    output logic              out_lo,
    output logic              out_hi,
    output logic              irq_lo,
    output logic              irq_hi
);
    logic tog_lo, tog_hi;
    logic pwm_lo, pwm_hi;

    assign pwm_lo = (cnt_lo < act.cmp_lo);
    assign pwm_hi = (cnt_hi < act.cmp_hi);

    always_ff @(posedge clk) begin
        if (rst || mode_wr) begin
            tog_lo <= 1'b0;
            tog_hi <= 1'b0;
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            if (ev_lo && lo_is_tog(mode)) tog_lo <= !tog_lo;
            if (ev_hi && (mode != MD_PWM8)) tog_hi <= !tog_hi;
            irq_lo <= ev_lo;
            irq_hi <= ev_hi;
        end
    end

    assign out_lo = lo_is_pwm(mode) ? pwm_lo : tog_lo;
    assign out_hi = (mode == MD_PWM8) ? pwm_hi : tog_hi;
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic              out_lo,
    output logic              out_hi,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq
);
    logic              mode_wr;
    tmr_mode_e         mode_q;
    tmr_cfg_t          act_q;
    tmr_load_t         ld;
    logic [HALF_W-1:0] cnt_lo, cnt_hi;
    logic              ev_lo, ev_hi;

    assign mode_wr = wr_en && (wr_addr == A_MODE);

    tmr_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_wr(mode_wr), .ld(ld),
        .mode(mode_q), .act(act_q)
    );

    tmr_core u_core (
        .clk(clk), .rst(rst), .tick(tick), .mode_wr(mode_wr),
        .mode(mode_q), .act(act_q), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .ev_lo(ev_lo), .ev_hi(ev_hi), .ld(ld)
    );

    tmr_wave u_wave (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode(mode_q),
        .act(act_q), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .ev_lo(ev_lo), .ev_hi(ev_hi), .out_lo(out_lo), .out_hi(out_hi),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    assign irq = irq_lo || irq_hi;
endmodule

// File: rtl/tmr_checks.sv
module tmr_checks
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              mode_wr,
    input tmr_mode_e         mode,
    input logic [HALF_W-1:0] cmp_lo,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] cnt_hi,
    input logic              out_lo,
    input logic              irq_lo,
    input logic              irq_hi
);
    // R8: an event pulse only ever follows a tick cycle
    p_irq_after_tick_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_lo || irq_hi) |-> $past(tick));

    // R3: zero compare in dual PWM mode keeps the low pin at 0
    p_pwm_zero_low_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_PWM8 && cmp_lo == '0) |-> !out_lo);

    // R7: a mode write leaves the counters and pulses cleared
    p_mode_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_wr)) |->
        (cnt_lo == '0 && cnt_hi == '0 && !irq_lo && !irq_hi));

    // R9: no tick, no count movement
    p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick) && !$past(mode_wr)) |->
        ($stable(cnt_lo) && $stable(cnt_hi)));

    // R2: in split toggle mode the low pin only moves after a tick
    p_tog_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mode_wr) && !$past(tick) &&
         mode == MD_TOG8 && $past(mode == MD_TOG8)) |-> $stable(out_lo));
endmodule

bind dual_pwm_timer tmr_checks u_chk (
    .clk(clk), .rst(rst), .tick(tick), .mode_wr(mode_wr), .mode(mode_q),
    .cmp_lo(act_q.cmp_lo), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .out_lo(out_lo), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/tb_dual_pwm_timer.sv
module tb_dual_pwm_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       out_lo, out_hi, irq_lo, irq_hi, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit running = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_mode, sp_lo, sp_hi, sc_lo, sc_hi, ap_lo, ap_hi, ac_lo, ac_hi;
    int c_lo, c_hi, t_lo, t_hi, i_lo, i_hi;

    dual_pwm_timer dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_lo(out_lo), .out_hi(out_hi),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        int e_lo, e_hi, v, full;
        cycles++;
        if (rst) begin
            m_mode = 0; sp_lo = 0; sp_hi = 0; sc_lo = 0; sc_hi = 0;
            ap_lo = 0; ap_hi = 0; ac_lo = 0; ac_hi = 0;
            c_lo = 0; c_hi = 0; t_lo = 0; t_hi = 0; i_lo = 0; i_hi = 0;
        end else if (wr_en && wr_addr == 0) begin
            m_mode = wr_data % 4;
            ap_lo = sp_lo; ap_hi = sp_hi; ac_lo = sc_lo; ac_hi = sc_hi;
            c_lo = 0; c_hi = 0; t_lo = 0; t_hi = 0; i_lo = 0; i_hi = 0;
        end else begin
            e_lo = 0; e_hi = 0;
            if (tick) begin
                if (m_mode == 0) begin
                    e_lo = (c_lo == ap_lo); e_hi = (c_hi == ap_hi);
                    c_lo = e_lo ? 0 : c_lo + 1;
                    c_hi = e_hi ? 0 : c_hi + 1;
                    if (e_lo) begin t_lo = 1 - t_lo; ap_lo = sp_lo; end
                    if (e_hi) begin t_hi = 1 - t_hi; ap_hi = sp_hi; end
                end else if (m_mode == 1) begin
                    e_lo = (c_lo == 255); e_hi = (c_hi == 255);
                    c_lo = (c_lo + 1) % 256; c_hi = (c_hi + 1) % 256;
                    if (e_lo) ac_lo = sc_lo;
                    if (e_hi) ac_hi = sc_hi;
                end else begin
                    v = c_hi * 256 + c_lo;
                    full = (v == ap_hi * 256 + ap_lo);
                    e_hi = full;
                    e_lo = (m_mode == 2) ? (c_lo == ap_lo) : (full || c_lo == 255);
                    v = full ? 0 : (v + 1) % 65536;
                    c_hi = v / 256; c_lo = v % 256;
                    if (full) begin t_hi = 1 - t_hi; ap_lo = sp_lo; ap_hi = sp_hi; end
                    if (m_mode == 2 && e_lo) t_lo = 1 - t_lo;
                    if (m_mode == 3 && e_lo) ac_lo = sc_lo;
                end
            end
            i_lo = e_lo; i_hi = e_hi;
            if (wr_en) begin
                case (wr_addr)
                    3'd1: sp_lo = wr_data;
                    3'd2: sp_hi = wr_data;
                    3'd3: sc_lo = wr_data;
                    3'd4: sc_hi = wr_data;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        int x_lo, x_hi;
        if (running && !rst) begin
            x_lo = (m_mode == 1 || m_mode == 3) ? int'(c_lo < ac_lo) : t_lo;
            x_hi = (m_mode == 1) ? int'(c_hi < ac_hi) : t_hi;
            check(cur_req, "out_lo", out_lo, x_lo);
            check(cur_req, "out_hi", out_hi, x_hi);
            check("R8", "irq_lo", irq_lo, i_lo);
            check("R8", "irq_hi", irq_hi, i_hi);
            check("R8", "irq", irq, (i_lo != 0 || i_hi != 0) ? 1 : 0);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = ((i % gap) == 0);
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the pins
        check("R1", "out_lo", out_lo, 0);
        check("R1", "out_hi", out_hi, 0);
        check("R1", "irq", irq, 0);
        running = 1'b1;

        cur_req = "R2";
        wr(1, 2); wr(2, 4); wr(0, 0);
        run(40, 1);
        cur_req = "R9";
        run(60, 3);
        cur_req = "R6";
        wr(1, 5);
        run(40, 1);

        cur_req = "R3";
        wr(3, 0); wr(4, 100); wr(0, 1);
        run(600, 1);
        cur_req = "R6";
        run(50, 1);
        wr(3, 255); wr(4, 1);
        run(600, 1);

        cur_req = "R4";
        wr(1, 3); wr(2, 1); wr(0, 2);
        run(800, 1);
        run(200, 2);

        cur_req = "R5";
        wr(1, 8'h20); wr(2, 1); wr(3, 8'h40); wr(0, 3);
        run(700, 1);
        cur_req = "R7";
        wr(3, 8'h10);
        wr(0, 3);
        // R7: right after the mode write the toggle pin and pulses are clear
        @(negedge clk);
        check("R7", "out_hi after mode write", out_hi, 0);
        check("R7", "irq after mode write", irq, 0);
        run(400, 1);

        running = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        while (cycles < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule